// File: doc/BRIEF.md
# Microcoded Context-Switch Sequencer

This block runs a short stored program of 24-bit instruction words that saves an engine's register state into a context memory or restores it from there. It fetches one word per cycle from an external instruction memory of up to 256 entries, addressed by its program counter and read combinationally. Every branch, wait and flag write names one bit of a single 128-bit flag space. Four of those bits are set by host-side request pulses. One bit mirrors the engine-busy input, and one bit always reads as 1.

A single direction flag decides what a transfer instruction does. The same instruction either copies a run of engine registers out to context memory (save) or copies context-memory words back into the registers (load). A transfer moves one word per cycle and advances a context-memory word pointer as it goes. A start pulse sets the program counter to 0 and loads the pointer from a base input. The program can later replace the pointer with the value of a 20-bit scratch register. Two control opcodes raise one-cycle pointer-handover pulses for the surrounding logic, and an end opcode puts the sequencer back to idle.

Top module: `ctxseq_top`

## Requirements
- R1: Bits 23:20 of an instruction select its class: 0x1 transfer, 0x2 scratch load, 0x4 branch, 0x5 wait, 0x6 control, 0x7 flag set. Any other class value takes one cycle, does nothing, and advances the program counter by one.
- R2: A transfer takes its word count from bits 19:14 and its first register index from bits 13:0. It moves one word per cycle on consecutive register indices and consecutive context addresses. It then continues at the next instruction with the pointer left one past the last word. A count of 0 moves nothing.
- R3: While flag 0 is 1, a transfer reads registers and writes context memory (save). While flag 0 is 0, it reads context memory and writes registers (load). Both write strobes are never high in the same cycle.
- R4: A scratch load places bits 19:0 of the instruction on `scratch_o`. Control opcode 0x60000A copies the scratch value into the context pointer.
- R5: A branch names its flag in bits 6:0, its polarity in bit 7 and its target address in bits 15:8. With bit 7 = 0 it is taken when the flag is 1. With bit 7 = 1 it is taken when the flag is 0. When not taken, execution continues at the next address.
- R6: A wait instruction (flag in bits 6:0, level in bit 7) holds the program counter until the flag equals bit 7.
- R7: A flag-set instruction writes bit 7 into the flag selected by bits 6:0. Writes to flag 96 and flag 104 are ignored. Flag 96 always reads the engine-busy input and flag 104 always reads 1.
- R8: A one-cycle pulse on the user-save, user-load, auto-save or auto-load request input sets flag 5, 6, 100 or 101 respectively. The flag stays set until a flag-set instruction clears it.
- R9: Control opcode 0x60000E raises `done_o` for one cycle and returns the sequencer to idle. 0x600007 pulses `ptr_swap_o` and 0x600009 pulses `ptr_commit_o`. Any other control opcode is a no-op.
- R10: A start pulse, whether the sequencer is idle or running, sets the program counter to 0 and the context pointer to `base_ptr_i` in the next cycle.
- R11: After reset the sequencer is idle with program counter 0, scratch 0 and all stored flags clear, and it drives no read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart the program |
| base_ptr_i | input | PTR_W | Context pointer loaded on start |
| usr_save_req_i | input | 1 | User-save request pulse (flag 5) |
| usr_load_req_i | input | 1 | User-load request pulse (flag 6) |
| auto_save_req_i | input | 1 | Auto-save request pulse (flag 100) |
| auto_load_req_i | input | 1 | Auto-load request pulse (flag 101) |
| engine_busy_i | input | 1 | Engine busy level (flag 96) |
| imem_addr_o | output | IADDR_W | Instruction fetch address (program counter) |
| imem_data_i | input | 24 | Instruction word at `imem_addr_o` |
| reg_addr_o | output | 14 | Engine register index |
| reg_rd_o | output | 1 | Engine register read strobe |
| reg_wr_o | output | 1 | Engine register write strobe |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Register read data (combinational) |
| ctx_addr_o | output | PTR_W | Context memory word address |
| ctx_rd_o | output | 1 | Context memory read strobe |
| ctx_wr_o | output | 1 | Context memory write strobe |
| ctx_wdata_o | output | DATA_W | Context memory write data |
| ctx_rdata_i | input | DATA_W | Context memory read data (combinational) |
| scratch_o | output | 20 | Scratch register value |
| ptr_swap_o | output | 1 | Pointer-swap control pulse |
| ptr_commit_o | output | 1 | Pointer-commit control pulse |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | End opcode executed this cycle |

## Verification
Assertions check several properties on every cycle. The save and load strobes never overlap, and no write happens outside a transfer. The pointer steps by one on each transfer cycle, and a stalled wait holds the program counter. A start always lands on address 0 with the base pointer, and an end always drops the sequencer to idle. In the flag file, an accepted flag write appears on the next cycle and a request pulse leaves its flag set. Only the bench scenarios show complete program outcomes. These include the order in which pending saves are taken before pending loads, whether the data comes back correctly after a save followed by a load, and that writes to the busy and always-true flags have no effect, seen through the branches that later read those flags.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;

  localparam int INSTR_W = 24;
  localparam int FIDX_W  = 7;
  localparam int XCNT_W  = 6;
  localparam int XREG_W  = 14;
  localparam int IMM_W   = 20;
  localparam int TGT_W   = 8;

  typedef enum logic [3:0] {
    OP_XFER   = 4'h1,
    OP_LDSCR  = 4'h2,
    OP_BRANCH = 4'h4,
    OP_WAIT   = 4'h5,
    OP_CTRL   = 4'h6,
    OP_SETF   = 4'h7
  } op_class_e;

  localparam logic [IMM_W-1:0] CTL_SWAP   = 20'h00007;
  localparam logic [IMM_W-1:0] CTL_COMMIT = 20'h00009;
  localparam logic [IMM_W-1:0] CTL_PTRLD  = 20'h0000A;
  localparam logic [IMM_W-1:0] CTL_END    = 20'h0000E;

  localparam int FLG_DIR   = 0;
  localparam int FLG_USAVE = 5;
  localparam int FLG_ULOAD = 6;
  localparam int FLG_BUSY  = 96;
  localparam int FLG_ASAVE = 100;
  localparam int FLG_ALOAD = 101;
  localparam int FLG_TRUE  = 104;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  typedef struct packed {
    op_class_e          cls;
    logic [XCNT_W-1:0]  xcnt;
    logic [XREG_W-1:0]  xreg;
    logic [IMM_W-1:0]   imm;
    logic [TGT_W-1:0]   tgt;
    logic               pol;
    logic [FIDX_W-1:0]  fidx;
  } instr_dec_t;

endpackage

// File: rtl/ctxseq_decode.sv
module ctxseq_decode
  import ctxseq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output instr_dec_t         dec_o
);

  always_comb begin
    dec_o.cls  = op_class_e'(instr_i[23:20]);
    dec_o.xcnt = instr_i[19:14];
    dec_o.xreg = instr_i[13:0];
    dec_o.imm  = instr_i[19:0];
    dec_o.tgt  = instr_i[15:8];
    dec_o.pol  = instr_i[7];
    dec_o.fidx = instr_i[6:0];
  end

endmodule

// File: rtl/ctxseq_flags.sv
module ctxseq_flags
  import ctxseq_pkg::*;
#(
  parameter int FLAG_N = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [FIDX_W-1:0] wr_idx_i,
  input  logic              wr_val_i,
  input  logic              usr_save_req_i,
  input  logic              usr_load_req_i,
  input  logic              auto_save_req_i,
  input  logic              auto_load_req_i,
  input  logic              engine_busy_i,
  input  logic [FIDX_W-1:0] rd_idx_i,
  output logic              rd_val_o,
  output logic              dir_o
);

  logic [FLAG_N-1:0] bit_q;
  logic [FLAG_N-1:0] req_vec;

  always_comb begin
    req_vec            = '0;
    req_vec[FLG_USAVE] = usr_save_req_i;
    req_vec[FLG_ULOAD] = usr_load_req_i;
    req_vec[FLG_ASAVE] = auto_save_req_i;
    req_vec[FLG_ALOAD] = auto_load_req_i;
  end

  for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
    if (gi == FLG_BUSY || gi == FLG_TRUE) begin : g_fixed
      assign bit_q[gi] = 1'b0;
    end else begin : g_store
      logic q;
      logic hit;
      logic en;
      assign hit = wr_en_i && (wr_idx_i == FIDX_W'(gi));
      assign en  = hit || req_vec[gi];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= req_vec[gi] | wr_val_i;
      end
      assign bit_q[gi] = q;
    end
  end

  always_comb begin
    if (rd_idx_i == FIDX_W'(FLG_BUSY))      rd_val_o = engine_busy_i;
    else if (rd_idx_i == FIDX_W'(FLG_TRUE)) rd_val_o = 1'b1;
    else                                    rd_val_o = bit_q[rd_idx_i];
  end

  assign dir_o = bit_q[FLG_DIR];

  // R7
  setf_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !req_vec[wr_idx_i] && wr_idx_i != FIDX_W'(FLG_BUSY)
     && wr_idx_i != FIDX_W'(FLG_TRUE))
    |=> bit_q[$past(wr_idx_i)] == $past(wr_val_i));

  // R8
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_load_req_i |=> bit_q[FLG_ULOAD]);

endmodule

// File: rtl/ctxseq_top.sv
module ctxseq_top
  import ctxseq_pkg::*;
#(
  parameter int IADDR_W = 8,
  parameter int PTR_W   = 16,
  parameter int DATA_W  = 32,
  parameter int FLAG_N  = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PTR_W-1:0]   base_ptr_i,
  input  logic               usr_save_req_i,
  input  logic               usr_load_req_i,
  input  logic               auto_save_req_i,
  input  logic               auto_load_req_i,
  input  logic               engine_busy_i,
  output logic [IADDR_W-1:0] imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  output logic [XREG_W-1:0]  reg_addr_o,
  output logic               reg_rd_o,
  output logic               reg_wr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  input  logic [DATA_W-1:0]  reg_rdata_i,
  output logic [PTR_W-1:0]   ctx_addr_o,
  output logic               ctx_rd_o,
  output logic               ctx_wr_o,
  output logic [DATA_W-1:0]  ctx_wdata_o,
  input  logic [DATA_W-1:0]  ctx_rdata_i,
  output logic [IMM_W-1:0]   scratch_o,
  output logic               ptr_swap_o,
  output logic               ptr_commit_o,
  output logic               busy_o,
  output logic               done_o
);

  seq_state_e          state_q, state_d;
  logic [IADDR_W-1:0]  pc_q, pc_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic [IMM_W-1:0]    scr_q, scr_d;
  logic [XREG_W-1:0]   xidx_q, xidx_d;
  logic [XCNT_W-1:0]   xleft_q, xleft_d;
  logic                run_en;

  instr_dec_t dec;
  logic       flag_rd;
  logic       dir;
  logic       fw_en;
  logic       in_xfer;

  ctxseq_decode u_dec (
    .instr_i (imem_data_i),
    .dec_o   (dec)
  );

  ctxseq_flags #(.FLAG_N(FLAG_N)) u_flags (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en_i         (fw_en),
    .wr_idx_i        (dec.fidx),
    .wr_val_i        (dec.pol),
    .usr_save_req_i  (usr_save_req_i),
    .usr_load_req_i  (usr_load_req_i),
    .auto_save_req_i (auto_save_req_i),
    .auto_load_req_i (auto_load_req_i),
    .engine_busy_i   (engine_busy_i),
    .rd_idx_i        (dec.fidx),
    .rd_val_o        (flag_rd),
    .dir_o           (dir)
  );

  // Next-state logic
  always_comb begin
    state_d      = state_q;
    pc_d         = pc_q;
    ptr_d        = ptr_q;
    scr_d        = scr_q;
    xidx_d       = xidx_q;
    xleft_d      = xleft_q;
    fw_en        = 1'b0;
    ptr_swap_o   = 1'b0;
    ptr_commit_o = 1'b0;
    done_o       = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        pc_d = pc_q + 1'b1;
        case (dec.cls)
          OP_XFER: begin
            if (dec.xcnt != '0) begin
              state_d = ST_XFER;
              pc_d    = pc_q;
              xidx_d  = dec.xreg;
              xleft_d = dec.xcnt;
            end
          end
          OP_LDSCR:  scr_d = dec.imm;
          OP_BRANCH: if (flag_rd != dec.pol) pc_d = IADDR_W'(dec.tgt);
          OP_WAIT:   if (flag_rd != dec.pol) pc_d = pc_q;
          OP_SETF:   fw_en = 1'b1;
          OP_CTRL: begin
            if (dec.imm == CTL_END) begin
              state_d = ST_IDLE;
              pc_d    = pc_q;
              done_o  = 1'b1;
            end
            if (dec.imm == CTL_SWAP)   ptr_swap_o   = 1'b1;
            if (dec.imm == CTL_COMMIT) ptr_commit_o = 1'b1;
            if (dec.imm == CTL_PTRLD)  ptr_d        = PTR_W'(scr_q);
          end
          default: ;
        endcase
      end
      ST_XFER: begin
        xidx_d  = xidx_q + 1'b1;
        ptr_d   = ptr_q + 1'b1;
        xleft_d = xleft_q - 1'b1;
        if (xleft_q == XCNT_W'(1)) begin
          state_d = ST_RUN;
          pc_d    = pc_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (start_i) begin
      state_d = ST_RUN;
      pc_d    = '0;
      ptr_d   = base_ptr_i;
    end
  end

  assign run_en = (state_q != ST_IDLE) || start_i;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ptr_q   <= '0;
      scr_q   <= '0;
      xidx_q  <= '0;
      xleft_q <= '0;
    end else if (run_en) begin
      pc_q    <= pc_d;
      ptr_q   <= ptr_d;
      scr_q   <= scr_d;
      xidx_q  <= xidx_d;
      xleft_q <= xleft_d;
    end
  end

  // Port drive
  assign in_xfer     = (state_q == ST_XFER);
  assign imem_addr_o = pc_q;
  assign reg_addr_o  = xidx_q;
  assign ctx_addr_o  = ptr_q;
  assign reg_rd_o    = in_xfer &&  dir;
  assign ctx_wr_o    = in_xfer &&  dir;
  assign ctx_rd_o    = in_xfer && !dir;
  assign reg_wr_o    = in_xfer && !dir;
  assign ctx_wdata_o = reg_rdata_i;
  assign reg_wdata_o = ctx_rdata_i;
  assign scratch_o   = scr_q;
  assign busy_o      = (state_q != ST_IDLE);

  // R3
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && ctx_wr_o));

  // R2
  xfer_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && !start_i) |=> ctx_addr_o == PTR_W'($past(ctx_addr_o) + 1'b1));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && dec.cls == OP_WAIT && flag_rd != dec.pol && !start_i)
    |=> (imem_addr_o == $past(imem_addr_o)) && busy_o);

  // R10
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (imem_addr_o == '0) && (ctx_addr_o == $past(base_ptr_i)) && busy_o);

  // R9
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(reg_wr_o || ctx_wr_o || reg_rd_o || ctx_rd_o));

endmodule

// File: tb/sim_ctxseq_top.sv
module sim_ctxseq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] base_ptr;
  logic        us_req, ul_req, as_req, al_req, eng_busy;
  logic [7:0]  imem_addr;
  logic [23:0] imem_data;
  logic [13:0] reg_addr;
  logic        reg_rd, reg_wr, ctx_rd, ctx_wr;
  logic [31:0] reg_wdata, reg_rdata, ctx_wdata, ctx_rdata;
  logic [15:0] ctx_addr;
  logic [19:0] scratch;
  logic        swp, cmt, busy, done;

  logic [23:0] prog [0:255];
  logic [31:0] regs [0:63];
  logic [31:0] cmem [0:255];
  logic        mem_init;
  int          n_ctxwr, n_regwr, n_commit, n_swap;
  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;

  always #2 clk = ~clk;

  ctxseq_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_ptr_i(base_ptr),
    .usr_save_req_i(us_req), .usr_load_req_i(ul_req),
    .auto_save_req_i(as_req), .auto_load_req_i(al_req),
    .engine_busy_i(eng_busy),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .reg_addr_o(reg_addr), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .ctx_addr_o(ctx_addr), .ctx_rd_o(ctx_rd), .ctx_wr_o(ctx_wr),
    .ctx_wdata_o(ctx_wdata), .ctx_rdata_i(ctx_rdata),
    .scratch_o(scratch), .ptr_swap_o(swp), .ptr_commit_o(cmt),
    .busy_o(busy), .done_o(done)
  );

  assign imem_data = prog[imem_addr];
  assign reg_rdata = regs[reg_addr[5:0]];
  assign ctx_rdata = cmem[ctx_addr[7:0]];

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 64; i++)  regs[i] <= 32'h1000 + i;
      for (int i = 0; i < 256; i++) cmem[i] <= 32'h2000 + i;
      n_ctxwr <= 0; n_regwr <= 0; n_commit <= 0; n_swap <= 0;
    end else begin
      if (reg_wr) begin regs[reg_addr[5:0]] <= reg_wdata; n_regwr <= n_regwr + 1; end
      if (ctx_wr) begin cmem[ctx_addr[7:0]] <= ctx_wdata; n_ctxwr <= n_ctxwr + 1; end
      if (cmt) n_commit <= n_commit + 1;
      if (swp) n_swap <= n_swap + 1;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mem_init = 1'b1; start = 1'b0;
    us_req = 0; ul_req = 0; as_req = 0; al_req = 0;
    @(negedge clk); @(negedge clk);
    mem_init = 1'b0; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 24'h000000;
  endtask

  // save-before-load program
  task automatic load_std();
    clear_prog();
    prog[0]  = 24'h400A64; prog[1]  = 24'h400A05; prog[2]  = 24'h400565;
    prog[3]  = 24'h400506; prog[4]  = 24'h401168; prog[5]  = 24'h500060;
    prog[6]  = 24'h700000; prog[7]  = 24'h400B68; prog[10] = 24'h700080;
    prog[11] = 24'h200040; prog[12] = 24'h60000A; prog[13] = 24'h110008;
    prog[14] = 24'h108014; prog[15] = 24'h400200; prog[16] = 24'h600009;
    prog[17] = 24'h700005; prog[18] = 24'h700006; prog[19] = 24'h60000E;
  endtask

  task automatic kick(input logic [3:0] req, input logic [15:0] base);
    {us_req, ul_req, as_req, al_req} = req;
    @(negedge clk);
    {us_req, ul_req, as_req, al_req} = 4'b0;
    base_ptr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_done(input int lim, output bit ok, output logic [7:0] at);
    ok = 0; at = '0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; at = imem_addr; break; end
    end
    @(negedge clk);
  endtask

  // {usave, uload, asave, aload, exp_save, exp_load}
  localparam logic [5:0] VEC [6] = '{6'b0000_00, 6'b1000_10, 6'b0100_01,
                                     6'b1100_11, 6'b0010_10, 6'b0001_01};

  initial begin
    bit         ok;
    logic [7:0] at;
    base_ptr = 16'h0; eng_busy = 1'b0;
    clear_prog();
    rst_n = 1'b0; mem_init = 1'b1; start = 1'b0;
    us_req = 0; ul_req = 0; as_req = 0; al_req = 0;
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk(!busy, "R11 busy", busy, 0);
    chk(imem_addr == 0, "R11 pc", imem_addr, 0);
    chk(scratch == 0, "R11 scratch", scratch, 0);
    chk(!reg_wr && !ctx_wr, "R11 writes", {reg_wr, ctx_wr}, 0);
    chk(!reg_rd && !ctx_rd, "R11 reads", {reg_rd, ctx_rd}, 0);
    mem_init = 1'b0; rst_n = 1'b1;

    // Table: request patterns through the save/load program (R3 R5 R8 R9)
    for (int v = 0; v < 6; v++) begin
      logic sv, ld;
      do_reset();
      load_std();
      sv = VEC[v][1]; ld = VEC[v][0];
      kick(VEC[v][5:2], 16'h0);
      run_done(400, ok, at);
      chk(ok && at == 8'd19, "R9 done at end", at, 19);
      chk(cmem[8'h40] == (sv ? 32'h1008 : 32'h2040), "R3 R8 save data", cmem[8'h40],
          sv ? 32'h1008 : 32'h2040);
      chk(regs[21] == ((ld && !sv) ? 32'h2045 : 32'h1015), "R3 R5 load data", regs[21],
          (ld && !sv) ? 32'h2045 : 32'h1015);
      chk(n_commit == int'(ld), "R9 commit pulses", n_commit, ld);
    end

    // Wait stall and restart (R6 R10)
    do_reset();
    load_std();
    eng_busy = 1'b1;
    kick(4'b0100, 16'h0);
    for (int i = 0; i < 30; i++) @(negedge clk);
    chk(imem_addr == 8'd5, "R6 wait holds pc", imem_addr, 5);
    chk(n_regwr == 0, "R6 no transfer while busy", n_regwr, 0);
    start = 1'b1;
    @(negedge clk);
    chk(imem_addr == 8'd0 && busy, "R10 restart pc", imem_addr, 0);
    start = 1'b0;
    for (int i = 0; i < 10; i++) @(negedge clk);
    eng_busy = 1'b0;
    run_done(400, ok, at);
    chk(ok && regs[8] == 32'h2040, "R6 load after release", regs[8], 32'h2040);

    // Writes to fixed flags ignored (R7)
    do_reset();
    clear_prog();
    prog[0] = 24'h700068; prog[1] = 24'h7000E0; prog[2] = 24'h500060;
    prog[3] = 24'h400568; prog[4] = 24'h60000E; prog[5] = 24'h60000E;
    kick(4'b0, 16'h0);
    run_done(100, ok, at);
    chk(ok && at == 8'd5, "R7 fixed flags unwritable", at, 5);

    // No-ops, scratch, branch on clear, save from base (R1 R2 R4 R5 R9 R10)
    do_reset();
    clear_prog();
    prog[0] = 24'h300000; prog[1] = 24'h600001; prog[2] = 24'h100005;
    prog[3] = 24'h2ABCDE; prog[4] = 24'h400680; prog[5] = 24'h60000E;
    prog[6] = 24'h700080; prog[7] = 24'h10C002; prog[8] = 24'h600007;
    prog[9] = 24'h60000E;
    kick(4'b0, 16'h0080);
    run_done(100, ok, at);
    chk(ok && at == 8'd9, "R1 R5 path end", at, 9);
    chk(scratch == 20'hABCDE, "R4 scratch", scratch, 20'hABCDE);
    chk(n_swap == 1, "R9 swap pulse", n_swap, 1);
    chk(n_commit == 0, "R9 no commit", n_commit, 0);
    chk(cmem[8'h80] == 32'h1002, "R10 R2 first word at base", cmem[8'h80], 32'h1002);
    chk(cmem[8'h82] == 32'h1004, "R2 last word", cmem[8'h82], 32'h1004);
    chk(cmem[8'h83] == 32'h2083, "R2 beyond count", cmem[8'h83], 32'h2083);
    chk(n_ctxwr == 3, "R2 zero count moves nothing", n_ctxwr, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule